// File: doc/BRIEF.md
# Keyed Clear-Alias Control Register

This block is the register front end of a multi-channel timer controller. It stores the 32-bit control word that drives the timer channels. Software can load that word directly. It can also clear individual bits through an alias address, where every 1 in the written data clears the matching control bit and every 0 leaves its bit alone.

The alias path is guarded by a one-bit unlock latch. Software arms the latch by writing an 8-bit key to a separate key address, and a different key disarms it. The key is taken from write-data bits [8:1], one position above the byte lane. While the latch is disarmed, writes to the alias do nothing. Unmapped accesses, and reads of the write-only alias, raise a one-cycle error flag and return zero.

The bus is a simple synchronous register port. Read data and the error flag are registered and valid in the cycle after the strobe. The control word is presented continuously on `ctrl_word`.

Top module: `keyed_clear_ctrl`

## Requirements
- R1: After synchronous reset, `ctrl_word`, the unlock latch, `bus_rdata` and `bus_err` are all zero.
- R2: A write to offset 0x30 loads all 32 bits of `bus_wdata` into the control word, and `ctrl_word` shows it one clock after the strobe. A read of 0x30 returns the full control word on `bus_rdata` one clock after `bus_rd`.
- R3: A read of offset 0x38 returns the unlock latch in bit 0 and zero in bits [31:1].
- R4: On a write to 0x38, the key byte is `bus_wdata[8:1]`. A key of 0xAE arms the latch and a key of 0xEA disarms it.
- R5: Any other key byte written to 0x38 leaves the latch unchanged. This includes 0xAE or 0xEA placed in bits [7:0].
- R6: A write to offset 0x3C while the latch is armed sets the control word to old AND NOT `bus_wdata`, visible on `ctrl_word` one clock after the strobe.
- R7: A write to offset 0x3C while the latch is disarmed leaves the control word unchanged.
- R8: A read of 0x3C, or any read or write at an offset other than 0x30, 0x38 or 0x3C, raises `bus_err` for exactly the one cycle after the strobe and returns zero. The access does not change the control word or the latch.
- R9: When `bus_rd` and `bus_wr` are both asserted on the same offset in one cycle, the read returns the value held before that write.
- R10: The alias write is gated by the latch value registered before its cycle. A key write arms or disarms the latch for the very next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_rd` |
| bus_err | output | 1 | One-cycle flag for an invalid access |
| ctrl_word | output | 32 | Current control word to the timer channels |

## Verification
Two functions can meet in one cycle: a read and a write of the same register, and a key write followed at once by an alias write. The bench provokes the first by raising both strobes at 0x30 together. It judges it by requiring the old word on `bus_rdata` and the new word on `ctrl_word`. It provokes the second with back-to-back arm-then-clear and disarm-then-clear sequences, with no idle cycle between them. It checks that only the armed sequence clears bits. All 256 key bytes are swept from both latch states, and all 256 offsets are swept for error and zero data.

// File: rtl/ckr_pkg.sv
package ckr_pkg;

    localparam int DATA_W_DEF = 32;
    localparam int ADDR_W_DEF = 8;
    localparam int KEY_W      = 8;
    localparam int KEY_LSB    = 1;

    localparam logic [7:0] OFS_CTRL  = 8'h30;
    localparam logic [7:0] OFS_KEY   = 8'h38;
    localparam logic [7:0] OFS_ALIAS = 8'h3C;

    localparam logic [KEY_W-1:0] KEY_ARM    = 8'hAE;
    localparam logic [KEY_W-1:0] KEY_DISARM = 8'hEA;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_KEY   = 2'd1,
        SEL_ALIAS = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        KEY_NOP = 2'd0,
        KEY_SET = 2'd1,
        KEY_CLR = 2'd2
    } key_cmd_e;

    typedef struct packed {
        reg_sel_e sel;
        logic     wr;
        logic     rd;
    } bus_op_t;

    function automatic key_cmd_e classify_key(logic [KEY_W-1:0] b);
        if (b == KEY_ARM)    return KEY_SET;
        if (b == KEY_DISARM) return KEY_CLR;
        return KEY_NOP;
    endfunction

endpackage

// File: rtl/ckr_decode.sv
module ckr_decode
    import ckr_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    output bus_op_t           op,
    output logic              bad_access
);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_KEY   = ADDR_W'(OFS_KEY);
    localparam logic [ADDR_W-1:0] A_ALIAS = ADDR_W'(OFS_ALIAS);

    reg_sel_e sel;

    always_comb begin
        if (addr == A_CTRL)       sel = SEL_CTRL;
        else if (addr == A_KEY)   sel = SEL_KEY;
        else if (addr == A_ALIAS) sel = SEL_ALIAS;
        else                      sel = SEL_NONE;
    end

    always_comb begin
        op.sel = sel;
        op.wr  = wr_en;
        op.rd  = rd_en;
        bad_access = ((wr_en || rd_en) && (sel == SEL_NONE))
                   || (rd_en && (sel == SEL_ALIAS));
    end

endmodule

// File: rtl/ckr_unlock.sv
module ckr_unlock
    import ckr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             key_we,
    input  logic [KEY_W-1:0] key_byte,
    output logic             armed
);
    key_cmd_e cmd;

    always_comb cmd = classify_key(key_byte);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
        end else if (key_we) begin
            case (cmd)
                KEY_SET: armed <= 1'b1;
                KEY_CLR: armed <= 1'b0;
                default: armed <= armed;
            endcase
        end
    end

    AST_KEY_ARMS: assert property (@(posedge clk) disable iff (rst)
        (key_we && key_byte == KEY_ARM) |=> armed); // R4
    AST_KEY_DISARMS: assert property (@(posedge clk) disable iff (rst)
        (key_we && key_byte == KEY_DISARM) |=> !armed); // R4
    AST_KEY_OTHER_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!key_we || (key_byte != KEY_ARM && key_byte != KEY_DISARM)) |=> $stable(armed)); // R5

endmodule

// File: rtl/ckr_ctrl_reg.sv
module ckr_ctrl_reg
    import ckr_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              direct_we,
    input  logic              alias_we,
    input  logic              armed,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_q
);
    logic clr_ok;
    logic [DATA_W-1:0] ctrl_d;

    always_comb clr_ok = alias_we && armed;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        always_comb begin
            if (direct_we)                 ctrl_d[i] = wdata[i];
            else if (clr_ok && wdata[i])   ctrl_d[i] = 1'b0;
            else                           ctrl_d[i] = ctrl_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else     ctrl_q <= ctrl_d;
    end

    AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (rst)
        direct_we |=> ctrl_q == $past(wdata)); // R2
    AST_ALIAS_ONLY_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (alias_we && !direct_we) |=> (ctrl_q & ~$past(ctrl_q)) == '0); // R6
    AST_ALIAS_CLEARS_MARKED: assert property (@(posedge clk) disable iff (rst)
        (alias_we && armed && !direct_we) |=> (ctrl_q & $past(wdata)) == '0); // R6
    AST_DISARMED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (alias_we && !armed && !direct_we) |=> $stable(ctrl_q)); // R7

endmodule

// File: rtl/keyed_clear_ctrl.sv
module keyed_clear_ctrl
    import ckr_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF,
    parameter int ADDR_W = ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    output logic [DATA_W-1:0] ctrl_word
);
    localparam int KEY_MSB = KEY_LSB + KEY_W - 1;

    initial begin
        if (DATA_W <= KEY_MSB) $error("DATA_W too narrow for the key field");
    end

    bus_op_t op;
    logic    bad;
    logic    armed;
    logic    key_we, direct_we, alias_we;
    logic [DATA_W-1:0] rd_mux;

    ckr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr       (bus_addr),
        .wr_en      (bus_wr),
        .rd_en      (bus_rd),
        .op         (op),
        .bad_access (bad)
    );

    always_comb begin
        key_we    = op.wr && (op.sel == SEL_KEY);
        direct_we = op.wr && (op.sel == SEL_CTRL);
        alias_we  = op.wr && (op.sel == SEL_ALIAS);
    end

    ckr_unlock u_key (
        .clk      (clk),
        .rst      (rst),
        .key_we   (key_we),
        .key_byte (bus_wdata[KEY_MSB:KEY_LSB]),
        .armed    (armed)
    );

    ckr_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .direct_we (direct_we),
        .alias_we  (alias_we),
        .armed     (armed),
        .wdata     (bus_wdata),
        .ctrl_q    (ctrl_word)
    );

    always_comb begin
        rd_mux = '0;
        if (op.rd) begin
            case (op.sel)
                SEL_CTRL: rd_mux = ctrl_word;
                SEL_KEY:  rd_mux = {{(DATA_W-1){1'b0}}, armed};
                default:  rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            bus_rdata <= rd_mux;
            bus_err   <= bad;
        end
    end

    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> bus_rdata == '0); // R8
    AST_KEY_READ_NARROW: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == ADDR_W'(OFS_KEY)) |=> bus_rdata[DATA_W-1:1] == '0); // R3
    AST_READ_BEFORE_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_wr && bus_addr == ADDR_W'(OFS_CTRL)) |=> bus_rdata == $past(ctrl_word)); // R9
    AST_BAD_WRITE_INERT: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bad) |=> $stable(ctrl_word)); // R8

endmodule

// File: tb/tb_keyed_clear_ctrl.sv
`timescale 1ns/1ps
module tb_keyed_clear_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [31:0] ctrl_word;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    keyed_clear_ctrl dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err),
        .ctrl_word (ctrl_word)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog act=%0d exp=<100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic e);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata; e = bus_err;
    endtask

    localparam logic [31:0] ARM_W    = 32'h0000_00AE << 1;
    localparam logic [31:0] DISARM_W = 32'h0000_00EA << 1;

    logic [31:0] d, a, b, lfsr;
    logic        e;

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ctrl", ctrl_word, 32'h0);
        chk("R1 rdata", bus_rdata, 32'h0);
        chk("R1 err", {31'b0, bus_err}, 32'h0);
        rst = 1'b0;
        rd(8'h38, d, e);
        chk("R1 latch", d, 32'h0);

        // R2 direct load and readback
        lfsr = 32'h1234_5678;
        for (int i = 0; i < 8; i++) begin
            lfsr = lfsr * 32'd1664525 + 32'd1013904223;
            wr(8'h30, lfsr);
            chk("R2 ctrl_word", ctrl_word, lfsr);
            rd(8'h30, d, e);
            chk("R2 readback", d, lfsr);
        end

        // R4 R5 R3 sweep of every key byte from both latch states
        for (int k = 0; k < 256; k++) begin
            wr(8'h38, ARM_W);
            wr(8'h38, 32'(k) << 1);
            rd(8'h38, d, e);
            chk((k == 8'hEA) ? "R4 disarm" : "R5 hold armed", d, (k == 8'hEA) ? 32'h0 : 32'h1);
            wr(8'h38, DISARM_W);
            wr(8'h38, 32'(k) << 1);
            rd(8'h38, d, e);
            chk((k == 8'hAE) ? "R4 arm" : "R5 hold disarmed", d, (k == 8'hAE) ? 32'h1 : 32'h0);
        end
        // R5 key in the byte lane is not a key; R3 upper bits zero
        wr(8'h38, DISARM_W);
        wr(8'h38, 32'h0000_00AE);
        rd(8'h38, d, e);
        chk("R5 unshifted arm", d, 32'h0);
        wr(8'h38, 32'hFFFF_FE00 | ARM_W);
        rd(8'h38, d, e);
        chk("R3 latch only bit0", d, 32'h1);
        wr(8'h38, 32'h0000_00EA);
        rd(8'h38, d, e);
        chk("R5 unshifted disarm", d, 32'h1);

        // R6 armed clear
        wr(8'h38, ARM_W);
        for (int i = 0; i < 16; i++) begin
            lfsr = lfsr * 32'd1664525 + 32'd1013904223;
            a = lfsr;
            lfsr = lfsr * 32'd1664525 + 32'd1013904223;
            b = (i == 0) ? 32'h0 : (i == 1) ? 32'hFFFF_FFFF : lfsr;
            wr(8'h30, a);
            wr(8'h3C, b);
            chk("R6 clear", ctrl_word, a & ~b);
        end

        // R7 disarmed alias write ignored
        wr(8'h38, DISARM_W);
        wr(8'h30, 32'hA5A5_5A5A);
        wr(8'h3C, 32'hFFFF_FFFF);
        chk("R7 ignored", ctrl_word, 32'hA5A5_5A5A);
        rd(8'h30, d, e);
        chk("R7 readback", d, 32'hA5A5_5A5A);

        // R8 offset sweep for reads
        for (int ad = 0; ad < 256; ad++) begin
            rd(8'(ad), d, e);
            chk("R8 err flag", {31'b0, e}, (ad == 8'h30 || ad == 8'h38) ? 32'h0 : 32'h1);
            if (ad != 8'h30 && ad != 8'h38) chk("R8 zero data", d, 32'h0);
        end
        // R8 error lasts one cycle; bad writes inert
        wr(8'h38, ARM_W);
        wr(8'h34, 32'hFFFF_FFFF);
        chk("R8 bad write err", {31'b0, bus_err}, 32'h1);
        chk("R8 bad write ctrl", ctrl_word, 32'hA5A5_5A5A);
        @(negedge clk);
        chk("R8 err one cycle", {31'b0, bus_err}, 32'h0);
        wr(8'h3C, 32'h0000_0000);
        chk("R8 alias write no err", {31'b0, bus_err}, 32'h0);

        // R9 simultaneous read and write
        @(negedge clk);
        bus_addr = 8'h30; bus_wdata = 32'h0F0F_1234; bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        chk("R9 old read", bus_rdata, 32'hA5A5_5A5A);
        chk("R9 new ctrl", ctrl_word, 32'h0F0F_1234);

        // R10 back-to-back key then alias
        wr(8'h38, DISARM_W);
        @(negedge clk);
        bus_addr = 8'h38; bus_wdata = ARM_W; bus_wr = 1'b1;
        @(negedge clk);
        bus_addr = 8'h3C; bus_wdata = 32'h0000_00FF;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R10 arm then clear", ctrl_word, 32'h0F0F_1200);
        @(negedge clk);
        bus_addr = 8'h38; bus_wdata = DISARM_W; bus_wr = 1'b1;
        @(negedge clk);
        bus_addr = 8'h3C; bus_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R10 disarm then clear", ctrl_word, 32'h0F0F_1200);

        // R1 reset again clears state
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 ctrl after reset", ctrl_word, 32'h0);
        rd(8'h38, d, e);
        chk("R1 latch after reset", d, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule